// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block produces the reset for a processor from three conditions. The first is a supply-good level that has already been digitized. The second is an active-low manual reset pin. The third is a watchdog strobe that the running software must keep toggling. The block drives an active-low reset and, when the variant has it, a complementary active-high reset. Each release of reset waits out a stretch of `TD_TICKS` clock cycles. Software that stops toggling the strobe for `TOUT_TICKS` cycles receives a full-length reset.

Three parameters build the variant: `HAS_MR` (manual reset present), `HAS_WDOG` (watchdog present) and `HAS_HIGH_OUT` (active-high output present). The manual reset and strobe inputs each pass through a two-flop synchronizer. Supply-good is used as it arrives, so a supply loss reaches the output without waiting for a clock edge.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_ok` is 0, `rst_out_n` is 0 in the same cycle, with no clock edge needed, and it stays 0.
- R2: After `supply_ok` rises, with manual reset inactive, `rst_out_n` returns to 1 on the `TD_TICKS`-th rising clock edge.
- R3: When `HAS_MR`=1, a low on `mr_n` forces `rst_out_n` to 0 from the 3rd edge onward. After `mr_n` returns high, a fresh stretch runs and `rst_out_n` returns to 1 on the (`TD_TICKS`+2)-th edge.
- R4: Every transition of `wd_strobe`, whether rising or falling, restarts the watchdog count. Once toggling stops, the timeout asserts reset on the (`TOUT_TICKS`+3)-th edge after the last transition.
- R5: When reset is released and no strobe transition occurs, reset asserts on the `TOUT_TICKS`-th edge after release. It is then held for exactly `TD_TICKS` edges, and the watchdog restarts so the next timeout again takes `TOUT_TICKS` edges.
- R6: Strobe transitions during reset have no effect. The watchdog count starts from zero on the cycle reset is released.
- R7: When `HAS_HIGH_OUT`=1, `rst_out` is always the complement of `rst_out_n`.
- R8: With `HAS_MR`=0, `HAS_WDOG`=0 and `HAS_HIGH_OUT`=0, `mr_n` has no effect, no timeout ever occurs, and `rst_out` is held at 0.
- R9: While `rst_ni` is 0, `rst_out_n` is 0 and `rst_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all counting |
| rst_ni | input | 1 | Asynchronous active-low initialization of the block's flops |
| supply_ok | input | 1 | Digitized supply-good level; 1 means the supply is above threshold |
| mr_n | input | 1 | Manual reset, active low; tie high when unused |
| wd_strobe | input | 1 | Watchdog strobe; either edge re-arms the watchdog |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high (0 when `HAS_HIGH_OUT`=0) |

## Verification
Two cases are hard to reach from the ports. The first is a timeout that fires a second time right after a timeout-induced reset. The second is a strobe edge that arrives while reset is held, which must not leave stale watchdog state. The bench releases reset, stays silent through two whole timeout cycles and measures each low and high span in edges. It then toggles the strobe both while supply is low and inside the stretch window after supply returns. Finally it checks that the next timeout still lands exactly `TOUT_TICKS` edges after release, which a counter not cleared on release would miss.

// File: rtl/rst_supervisor.sv
`timescale 1ns/1ps
module rst_supervisor #(
  parameter int TD_TICKS     = 180000,
  parameter int TOUT_TICKS   = 1400000,
  parameter int HAS_MR       = 1,
  parameter int HAS_WDOG     = 1,
  parameter int HAS_HIGH_OUT = 1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic supply_ok,
  input  logic mr_n,
  input  logic wd_strobe,
  output logic rst_out_n,
  output logic rst_out
);
  localparam int TD_W = $clog2(TD_TICKS + 1);
  localparam int WD_W = $clog2(TOUT_TICKS + 1);
  localparam logic [TD_W-1:0] TD_LAST = TD_W'(TD_TICKS - 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TOUT_TICKS - 1);

  logic [1:0]      mr_sync;
  logic [2:0]      wd_sync;
  logic            active;
  logic [TD_W-1:0] td_cnt;
  logic [WD_W-1:0] wd_cnt;
  logic            hold, wd_edge, wd_fire;

  always_ff @(posedge clk or negedge rst_ni)
    if (!rst_ni) begin
      mr_sync <= 2'b11;
      wd_sync <= 3'b000;
    end else begin
      mr_sync <= {mr_sync[0], mr_n};
      wd_sync <= {wd_sync[1:0], wd_strobe};
    end

  assign hold    = !supply_ok || (HAS_MR != 0 && !mr_sync[1]);
  assign wd_edge = wd_sync[2] ^ wd_sync[1];
  assign wd_fire = (HAS_WDOG != 0) && !active && !hold && !wd_edge && (wd_cnt == WD_LAST);

  always_ff @(posedge clk or negedge rst_ni)
    if (!rst_ni) begin
      active <= 1'b1;
      td_cnt <= '0;
    end else if (hold || wd_fire) begin
      active <= 1'b1;
      td_cnt <= '0;
    end else if (active) begin
      if (td_cnt == TD_LAST) begin
        active <= 1'b0;
        td_cnt <= '0;
      end else begin
        td_cnt <= td_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_ni)
    if (!rst_ni)
      wd_cnt <= '0;
    else if (HAS_WDOG == 0 || active || hold || wd_edge || wd_fire)
      wd_cnt <= '0;
    else
      wd_cnt <= wd_cnt + 1'b1;

  assign rst_out_n = supply_ok && !active;
  assign rst_out   = (HAS_HIGH_OUT != 0) ? !rst_out_n : 1'b0;

  p_supply_hold_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !supply_ok |=> active);
  p_release_count_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(active) |-> $past(td_cnt) == TD_LAST);
  p_mr_force_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (HAS_MR != 0 && !mr_sync[1]) |=> active);
  p_edge_rearm_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (wd_edge && !active) |=> wd_cnt == '0);
  p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    wd_fire |=> (active && td_cnt == '0 && wd_cnt == '0));
  p_wd_frozen_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    active |=> wd_cnt == '0);
endmodule

// File: tb/rst_supervisor_tb.sv
`timescale 1ns/1ps
module rst_supervisor_tb;
  localparam int TD = 8;
  localparam int TO = 12;

  logic clk = 0;
  logic rst_ni = 0, supply_ok = 0, mr_n = 1, wd_strobe = 0;
  logic rst_out_n, rst_out, v_rst_out_n, v_rst_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_supervisor #(.TD_TICKS(TD), .TOUT_TICKS(TO)) u_dut (
    .clk(clk), .rst_ni(rst_ni), .supply_ok(supply_ok), .mr_n(mr_n),
    .wd_strobe(wd_strobe), .rst_out_n(rst_out_n), .rst_out(rst_out));

  rst_supervisor #(.TD_TICKS(TD), .TOUT_TICKS(TO), .HAS_MR(0), .HAS_WDOG(0), .HAS_HIGH_OUT(0)) u_var (
    .clk(clk), .rst_ni(rst_ni), .supply_ok(supply_ok), .mr_n(mr_n),
    .wd_strobe(wd_strobe), .rst_out_n(v_rst_out_n), .rst_out(v_rst_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_until(input logic want, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (rst_out_n !== want && n < 500);
  endtask

  task automatic t_init();
    repeat (3) @(negedge clk);
    check(rst_out_n === 1'b0, "R9 low out", rst_out_n, 0);
    check(rst_out === 1'b1, "R9 high out", rst_out, 1);
    rst_ni = 1;
  endtask

  task automatic t_power_up();
    int n;
    supply_ok = 1;
    count_until(1'b1, n);
    check(n == TD, "R2 release delay", n, TD);
    check(rst_out === 1'b0, "R7 high out released", rst_out, 0);
  endtask

  task automatic t_timeout();
    int n;
    count_until(1'b0, n);
    check(n == TO, "R5 first timeout", n, TO);
    count_until(1'b1, n);
    check(n == TD, "R5 timeout reset length", n, TD);
    count_until(1'b0, n);
    check(n == TO, "R5 watchdog reinit", n, TO);
    count_until(1'b1, n);
    check(n == TD, "R5 second reset length", n, TD);
  endtask

  task automatic t_kick();
    int n, drops;
    drops = 0;
    for (int i = 0; i < 10; i++) begin
      wd_strobe = ~wd_strobe;
      for (int j = 0; j < 5; j++) begin
        @(negedge clk);
        if (rst_out_n !== 1'b1) drops++;
      end
    end
    check(drops == 0, "R4 kicks hold off reset", drops, 0);
    wd_strobe = ~wd_strobe;
    count_until(1'b0, n);
    check(n == TO + 3, "R4 timeout after last edge", n, TO + 3);
    count_until(1'b1, n);
  endtask

  task automatic t_mr();
    int n;
    mr_n = 0;
    count_until(1'b0, n);
    check(n == 3, "R3 manual assert latency", n, 3);
    repeat (20) @(negedge clk);
    check(rst_out_n === 1'b0, "R3 manual held", rst_out_n, 0);
    mr_n = 1;
    count_until(1'b1, n);
    check(n == TD + 2, "R3 manual release delay", n, TD + 2);
  endtask

  task automatic t_supply_drop();
    int n, highs;
    highs = 0;
    supply_ok = 0;
    #1;
    check(rst_out_n === 1'b0, "R1 immediate assert", rst_out_n, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 3 == 0) wd_strobe = ~wd_strobe;
      if (rst_out_n !== 1'b0) highs++;
    end
    check(highs == 0, "R1 held while supply low", highs, 0);
    repeat (4) @(negedge clk);
    supply_ok = 1;
    wd_strobe = ~wd_strobe;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) wd_strobe = ~wd_strobe;
    end while (rst_out_n !== 1'b1 && n < 500);
    check(n == TD, "R2 release after drop", n, TD);
    count_until(1'b0, n);
    check(n == TO, "R6 strobes in reset ignored", n, TO);
    count_until(1'b1, n);
  endtask

  task automatic t_variant();
    int bad, mism;
    bad = 0;
    mism = 0;
    for (int i = 0; i < 3 * TO; i++) begin
      @(negedge clk);
      if (v_rst_out_n !== 1'b1) bad++;
      if (rst_out !== !rst_out_n) mism++;
    end
    check(bad == 0, "R8 no watchdog in variant", bad, 0);
    mr_n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (v_rst_out_n !== 1'b1 || v_rst_out !== 1'b0) bad++;
      if (rst_out !== !rst_out_n) mism++;
    end
    check(bad == 0, "R8 manual reset ignored in variant", bad, 0);
    check(rst_out_n === 1'b0, "R3 main forced by manual", rst_out_n, 0);
    check(mism == 0, "R7 complement output", mism, 0);
    mr_n = 1;
    repeat (TD + 4) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_init();
    t_power_up();
    t_timeout();
    t_kick();
    t_mr();
    t_supply_drop();
    t_variant();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule